// File: doc/BRIEF.md
# Pixel Stream to FIFO Sink

This block is the last stage of a streaming pixel pipeline. It receives one beat per clock from an upstream stage over a valid/ready handshake. Each beat carries a pixel field and three flags: a data-valid bit, an end-of-line marker and an end-of-image marker. Beats that carry pixel data are packed into words and written to an internal synchronous FIFO. A host transfer channel drains that FIFO through a show-ahead read port.

Two parameters select the variant. `PIX_KIND` sets the pixel format: 1-bit, 8-bit, 16-bit, or 32-bit with four 8-bit planes. `PIX_PER_BEAT` sets whether a beat holds one pixel or eight. The FIFO entry width follows from the pixel format.

The ready output is a promise for the following cycle. The upstream stage may only count on a transfer in a cycle that follows a cycle in which ready was high. The block computes ready from the FIFO level it will have after the current edge, so an accepted beat always finds room.

Top module: `pix_fifo_sink`

## Requirements
- R1: After synchronous active-high reset, `fifo_empty` is 1, `fifo_full` is 0 and `in_ready` is 1.
- R2: A beat with `in_valid`=1 and `in_dv`=1 is written as exactly one FIFO word, provided `in_ready` was 1 in the previous cycle. Words leave through `rd_data` in arrival order.
- R3: An accepted beat with `in_dv`=0 writes nothing, whatever its `in_eol`, `in_eoi` and pixel field are. A beat with `in_dv`=1 and a marker set still writes its pixel.
- R4: A cycle with `in_valid`=0 writes nothing, even when `in_dv`=1.
- R5: While `fifo_full` is 1, `in_ready` is 0 in that same cycle, even when a read is requested.
- R6: A beat presented in the cycle after `in_ready` was 0 is discarded, even with `in_valid`=1 and `in_dv`=1.
- R7: 1-bit and 8-bit pixels take 8-bit entries. A 1-bit pixel sits in bit 0 of its entry and the upper seven bits are zero. 16-bit pixels take 16-bit entries.
- R8: A 32-bit pixel is taken from `in_data` as four bytes: alpha in bits 31:24, first plane in 23:16, second plane in 15:8, third plane in 7:0. It is stored in a 32-bit entry with the same layout.
- R9: With `PIX_PER_BEAT`=8, one accepted data beat writes one FIFO word holding all eight entries. Pixel i is read from `in_data[i*P +: P]`, where P is the pixel width, and is stored in `rd_data[i*E +: E]`, where E is the entry width. Pixel 0 is therefore in the least significant slot.
- R10: No write occurs while the FIFO is full. Exactly `DEPTH` words can be stored.
- R11: `rd_en` on an empty FIFO has no effect. `rd_data` shows the oldest word whenever `fifo_empty` is 0, and `rd_en` removes it at the next edge.
- R12: A write and a read in the same cycle leave the level unchanged. At level `DEPTH`-1 this keeps `in_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream beat present |
| in_data | input | PIX_PER_BEAT × pixel bits (default 32) | Pixel field of the beat |
| in_dv | input | 1 | Pixel field holds real data |
| in_eol | input | 1 | End-of-line marker |
| in_eoi | input | 1 | End-of-image marker |
| in_ready | output | 1 | A beat offered next cycle will be taken |
| rd_en | input | 1 | Host pop request |
| rd_data | output | PIX_PER_BEAT × entry bits (default 32) | Oldest FIFO word (show-ahead) |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no word |

## Verification
A host pop and an upstream write can land in the same cycle. The case that matters is when the FIFO holds one word fewer than its depth: the ready decision then depends on both at once. The bench fills the FIFO to that level and presents a data beat together with `rd_en`. It expects the level to stay put and ready to stay high. The bench also pops while the FIFO is full, and expects ready to stay low in that cycle and the beat offered just after to be dropped. A behavioural queue model judges every cycle, comparing ready, the full and empty flags, and the head word.

// File: rtl/pix_sink_pkg.sv
package pix_sink_pkg;

    typedef enum logic [1:0] {
        PK_BIT1 = 2'd0,
        PK_BYTE = 2'd1,
        PK_HALF = 2'd2,
        PK_QUAD = 2'd3
    } pix_kind_e;

    typedef enum logic [2:0] {
        BC_IDLE  = 3'd0,
        BC_DROP  = 3'd1,
        BC_PIXEL = 3'd2,
        BC_LINE  = 3'd3,
        BC_FRAME = 3'd4
    } beat_class_e;

    typedef struct packed {
        logic valid;
        logic dv;
        logic eol;
        logic eoi;
    } beat_ctl_t;

    typedef struct packed {
        logic [7:0] alpha;
        logic [7:0] c1;
        logic [7:0] c2;
        logic [7:0] c3;
    } quad_px_t;

    function automatic int pix_bits(pix_kind_e k);
        case (k)
            PK_BIT1: return 1;
            PK_BYTE: return 8;
            PK_HALF: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic int slot_bits(pix_kind_e k);
        case (k)
            PK_BIT1, PK_BYTE: return 8;
            PK_HALF:          return 16;
            default:          return 32;
        endcase
    endfunction

endpackage

// File: rtl/pix_beat_gate.sv
module pix_beat_gate
    import pix_sink_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  beat_ctl_t   ctl,
    input  logic        ready_now,
    output beat_class_e cls,
    output logic        wr_req
);

    logic promised_q;

    always_ff @(posedge clk) begin
        if (rst) promised_q <= 1'b1;
        else     promised_q <= ready_now;
    end

    always_comb begin
        if (!ctl.valid)        cls = BC_IDLE;
        else if (!promised_q)  cls = BC_DROP;
        else if (ctl.dv)       cls = BC_PIXEL;
        else if (ctl.eoi)      cls = BC_FRAME;
        else if (ctl.eol)      cls = BC_LINE;
        else                   cls = BC_IDLE;
    end

    assign wr_req = (cls == BC_PIXEL);

endmodule

// File: rtl/pix_lane_pack.sv
module pix_lane_pack
    import pix_sink_pkg::*;
#(
    parameter pix_kind_e KIND = PK_QUAD,
    parameter int        PPB  = 1,
    localparam int       PW   = pix_bits(KIND),
    localparam int       EW   = slot_bits(KIND)
) (
    input  logic [PPB*PW-1:0] px_in,
    output logic [PPB*EW-1:0] word_out
);

    for (genvar g = 0; g < PPB; g++) begin : g_lane
        logic [PW-1:0] px;
        assign px = px_in[g*PW +: PW];

        if (KIND == PK_QUAD) begin : g_quad
            quad_px_t q;
            assign q = px;
            assign word_out[g*EW +: EW] = {q.alpha, q.c1, q.c2, q.c3};
        end else if (EW > PW) begin : g_widen
            assign word_out[g*EW +: EW] = {{(EW-PW){1'b0}}, px};
        end else begin : g_same
            assign word_out[g*EW +: EW] = px;
        end
    end

endmodule

// File: rtl/pix_sync_fifo.sv
module pix_sync_fifo #(
    parameter int  W      = 32,
    parameter int  DEPTH  = 16,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty,
    output logic         room_next
);

    logic [W-1:0]      mem [DEPTH];
    logic [ADDR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0]  level;
    logic [CNT_W:0]    lvl_next;
    logic              do_rd;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rptr];

    assign lvl_next  = {1'b0, level} + (CNT_W+1)'(wr_en) - (CNT_W+1)'(do_rd);
    assign room_next = (lvl_next < (CNT_W+1)'(DEPTH));

    function automatic logic [ADDR_W-1:0] bump(logic [ADDR_W-1:0] p);
        return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_en) wptr <= bump(wptr);
            if (do_rd) rptr <= bump(rptr);
            level <= lvl_next[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

endmodule

// File: rtl/pix_fifo_sink.sv
module pix_fifo_sink
    import pix_sink_pkg::*;
#(
    parameter pix_kind_e PIX_KIND     = PK_QUAD,
    parameter int        PIX_PER_BEAT = 1,
    parameter int        DEPTH        = 16,
    localparam int       IN_W         = PIX_PER_BEAT * pix_bits(PIX_KIND),
    localparam int       WORD_W       = PIX_PER_BEAT * slot_bits(PIX_KIND)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    input  logic              in_dv,
    input  logic              in_eol,
    input  logic              in_eoi,
    output logic              in_ready,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              fifo_full,
    output logic              fifo_empty
);

    beat_ctl_t         ctl;
    beat_class_e       cls;
    logic              wr_en;
    logic              room_next;
    logic [WORD_W-1:0] packed_word;

    assign ctl = '{valid: in_valid, dv: in_dv, eol: in_eol, eoi: in_eoi};

    pix_beat_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .ready_now (in_ready),
        .cls       (cls),
        .wr_req    (wr_en)
    );

    pix_lane_pack #(
        .KIND (PIX_KIND),
        .PPB  (PIX_PER_BEAT)
    ) u_pack (
        .px_in    (in_data),
        .word_out (packed_word)
    );

    pix_sync_fifo #(
        .W     (WORD_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (packed_word),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .room_next (room_next)
    );

    assign in_ready = !fifo_full && room_next;

endmodule

// File: rtl/pix_fifo_sink_chk.sv
module pix_fifo_sink_chk
    import pix_sink_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_dv,
    input logic        in_ready,
    input logic        rd_en,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        wr_en,
    input beat_class_e cls
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (fifo_empty && !fifo_full && in_ready));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> (wr_en == (in_valid && in_dv)));

    p_marker_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
        (cls == BC_LINE || cls == BC_FRAME) |-> !wr_en);

    p_idle_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !wr_en);

    p_full_notready_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !in_ready);

    p_drop_after_low_r6: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> !wr_en);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !fifo_full);

    p_empty_read_r11: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && !wr_en) |=> fifo_empty);

endmodule

bind pix_fifo_sink pix_fifo_sink_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_dv      (in_dv),
    .in_ready   (in_ready),
    .rd_en      (rd_en),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .wr_en      (wr_en),
    .cls        (cls)
);

// File: tb/tb_pix_fifo_sink.sv
`timescale 1ns/1ps
module tb_pix_fifo_sink;
    import pix_sink_pkg::*;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_dv = 1'b0, in_eol = 1'b0, in_eoi = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] din = '0;

    logic        rdy_a, full_a, empty_a, rdy_b, full_b, empty_b;
    logic [31:0] rd_a;
    logic [63:0] rd_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] qa[$];
    logic [63:0] qb[$];
    bit prev_a = 1'b1, prev_b = 1'b1;

    always #2 clk = ~clk;

    pix_fifo_sink #(.PIX_KIND(PK_QUAD), .PIX_PER_BEAT(1), .DEPTH(D)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(din),
        .in_dv(in_dv), .in_eol(in_eol), .in_eoi(in_eoi), .in_ready(rdy_a),
        .rd_en(rd_en), .rd_data(rd_a), .fifo_full(full_a), .fifo_empty(empty_a));

    pix_fifo_sink #(.PIX_KIND(PK_BIT1), .PIX_PER_BEAT(8), .DEPTH(D)) dut_b (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(din[7:0]),
        .in_dv(in_dv), .in_eol(in_eol), .in_eoi(in_eoi), .in_ready(rdy_b),
        .rd_en(rd_en), .rd_data(rd_b), .fifo_full(full_b), .fifo_empty(empty_b));

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_bits(logic [7:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++) r[i*8] = b[i];
        return r;
    endfunction

    task automatic step(bit v, bit dv, bit eol, bit eoi, bit rd, logic [31:0] d, string tag);
        int sz;
        bit we, re, er;
        @(negedge clk);
        in_valid = v; in_dv = dv; in_eol = eol; in_eoi = eoi; rd_en = rd; din = d;
        #1;
        // model for the 32-bit single-pixel instance
        sz = qa.size();
        we = v && prev_a && dv;
        re = rd && (sz > 0);
        er = (sz != D) && (sz + int'(we) - int'(re) < D);
        chk(rdy_a == er, tag, "ready a (R5/R6/R12)", 64'(rdy_a), 64'(er));
        chk(full_a == (sz == D), tag, "full a (R10)", 64'(full_a), 64'(sz == D));
        chk(empty_a == (sz == 0), tag, "empty a (R11)", 64'(empty_a), 64'(sz == 0));
        if (sz > 0) chk(rd_a == qa[0], tag, "head a (R2)", 64'(rd_a), 64'(qa[0]));
        if (re) void'(qa.pop_front());
        if (we) qa.push_back(d);
        prev_a = er;
        // model for the 1-bit eight-pixel instance
        sz = qb.size();
        we = v && prev_b && dv;
        re = rd && (sz > 0);
        er = (sz != D) && (sz + int'(we) - int'(re) < D);
        chk(rdy_b == er, tag, "ready b (R5/R6/R12)", 64'(rdy_b), 64'(er));
        chk(full_b == (sz == D), tag, "full b (R10)", 64'(full_b), 64'(sz == D));
        chk(empty_b == (sz == 0), tag, "empty b (R11)", 64'(empty_b), 64'(sz == 0));
        if (sz > 0) chk(rd_b == qb[0], tag, "head b (R2)", rd_b, qb[0]);
        if (re) void'(qb.pop_front());
        if (we) qb.push_back(pack_bits(d[7:0]));
        prev_b = er;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog act=timeout exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(empty_a && !full_a && rdy_a, "R1", "reset state a", {61'd0, empty_a, full_a, rdy_a}, 64'h5);
        chk(empty_b && !full_b && rdy_b, "R1", "reset state b", {61'd0, empty_b, full_b, rdy_b}, 64'h5);

        // data beats, one with a line marker
        step(1, 1, 0, 0, 0, 32'hA1B2C3D4, "R2");
        step(1, 1, 1, 0, 0, 32'h00000001, "R3");
        step(0, 0, 0, 0, 0, 32'h0, "R4");
        chk(rd_a == 32'hA1B2C3D4, "R8", "quad layout", 64'(rd_a), 64'hA1B2C3D4);
        chk(rd_a[31:24] == 8'hA1, "R8", "alpha byte", 64'(rd_a[31:24]), 64'hA1);
        chk(rd_b == 64'h0101000100010000, "R9", "eight 1-bit lanes", rd_b, 64'h0101000100010000);

        // marker-only and idle beats
        step(1, 0, 1, 0, 0, 32'hFFFFFFFF, "R3");
        step(1, 0, 0, 1, 0, 32'hFFFFFFFF, "R3");
        step(1, 0, 1, 1, 0, 32'h5A5A5A5A, "R3");
        step(0, 1, 0, 0, 0, 32'hEEEEEEEE, "R4");
        step(0, 0, 0, 0, 1, 32'h0, "R2");
        step(0, 0, 0, 0, 0, 32'h0, "R3");
        chk(rd_a == 32'h00000001, "R3", "next word after markers", 64'(rd_a), 64'h1);
        chk(rd_b == 64'h1, "R7", "1-bit zero extended", rd_b, 64'h1);
        step(0, 0, 0, 0, 1, 32'h0, "R11");
        step(0, 0, 0, 0, 1, 32'h0, "R11");
        step(0, 0, 0, 0, 0, 32'h0, "R11");
        chk(empty_a && empty_b, "R11", "still empty after empty read", {63'd0, empty_a && empty_b}, 64'h1);

        // fill past depth
        for (int i = 0; i < D + 4; i++)
            step(1, 1, 0, 0, 0, 32'h11000000 + 32'(i * 7), "R10");
        step(0, 0, 0, 0, 0, 32'h0, "R5");
        chk(full_a && !rdy_a, "R5", "full drops ready", {62'd0, full_a, rdy_a}, 64'h2);
        chk(qa.size() == D, "R10", "stored words", 64'(qa.size()), 64'(D));

        // pop while full, then offer beats around the ready edge
        step(1, 1, 0, 0, 1, 32'h22000001, "R5");
        step(1, 1, 0, 0, 0, 32'h22000002, "R6");
        step(1, 1, 0, 0, 0, 32'h22000003, "R6");
        step(0, 0, 0, 0, 0, 32'h0, "R6");
        chk(full_a, "R6", "refilled by one beat only", 64'(full_a), 64'h1);
        for (int i = 0; i < D; i++) step(0, 0, 0, 0, 1, 32'h0, "R6");
        step(0, 0, 0, 0, 0, 32'h0, "R11");
        chk(empty_a && empty_b, "R6", "drained after depth reads", {63'd0, empty_a && empty_b}, 64'h1);

        // fill to depth-1 then write and read together
        for (int i = 0; i < D - 1; i++)
            step(1, 1, 0, 0, 0, 32'h33000000 + 32'(i), "R12");
        step(1, 1, 0, 0, 1, 32'h33FF00AA, "R12");
        step(0, 0, 0, 0, 0, 32'h0, "R12");
        chk(!full_a && rdy_a, "R12", "level held at depth-1", {62'd0, full_a, rdy_a}, 64'h1);
        for (int i = 0; i < D; i++) step(0, 0, 0, 0, 1, 32'h0, "R2");
        step(0, 0, 0, 0, 0, 32'h0, "R11");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule